// File: doc/BRIEF.md
# Bounded Transactional Line Tracker

This block keeps the bookkeeping for a small hardware transaction run by one core. The transaction first names the cache lines it intends to use through protected loads. Each new distinct line takes one tracking entry. An acquire command then checks that no tracked line has been disturbed by a remote agent. If none has, the acquire records the instruction pointer and stack pointer as the rollback checkpoint and opens the critical section. Inside the critical section the core may store only to tracked lines. The transaction ends with a commit or an abort.

Remote invalidations and remote writes are presented on a snoop port and compared with every tracked line. A hit before the acquire makes the acquire fail. A hit inside the critical section ends the transaction at once. Each ending is reported for one cycle as a completion pulse with a reason code. Endings that leave the critical section early also present the checkpointed pointers so the core can roll back. Every ending clears all entries in one cycle.

The controller has three named states. IDLE has no transaction. GATHER is the state in which protected loads collect lines. CRIT is the critical section that follows a successful acquire. The transitions are as follows:
- IDLE to GATHER on the first protected load.
- GATHER to CRIT on an acquire with no disturbance.
- GATHER to IDLE on a capacity overflow, a conflict at acquire, an early store or commit, or an abort.
- CRIT to IDLE on a commit, an abort, a stray store, or a snoop conflict.

Top module: `txn_line_tracker`

## Requirements
- R1: After reset the phase output is 0 (IDLE), the line count is 0, and no completion or rollback pulse is present.
- R2: A protected load (op code 1) to a line that is not tracked, issued in IDLE or GATHER, adds one entry, raises the count by one, and leaves the phase at 1 (GATHER).
- R3: A protected load to a line that is already tracked leaves the count unchanged and produces no completion.
- R4: Up to NUM_LINES (default 8) distinct lines are tracked. A protected load that needs one more distinct line ends the transaction with code 1 (capacity).
- R5: An acquire (op code 2) in GATHER with no disturbance moves the phase to 2 (CRIT), produces no completion, and checkpoints the IP and SP inputs presented with it.
- R6: A snoop that hits a tracked line in GATHER, either before or in the same cycle as the acquire, makes the acquire end the transaction with code 2 (conflict) and no rollback. A snoop that misses every tracked line has no effect.
- R7: A snoop hit on a tracked line in CRIT ends the transaction with code 2 and pulses the rollback output carrying the checkpointed IP and SP.
- R8: In CRIT a store (op code 3) to a tracked line has no effect. A store to an untracked line ends the transaction with code 3 (stray) and a rollback.
- R9: A store or a commit issued in GATHER ends the transaction with code 5 (order) and no rollback.
- R10: A commit (op code 4) in CRIT ends with code 0 and no rollback. An abort (op code 5) ends with code 4, with a rollback only when it is issued in CRIT.
- R11: Every ending appears as a one-cycle completion pulse in the cycle after the command or snoop. In that same cycle the phase is 0 and the count is 0.
- R12: In IDLE every command other than a protected load, and every snoop, is ignored.
- R13: In CRIT a snoop hit takes priority over a command in the same cycle, and that command is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 1 load, 2 acquire, 3 store, 4 commit, 5 abort |
| cmd_line | input | LINE_W | Line address of a load or store |
| cmd_ip | input | PTR_W | Instruction pointer taken at acquire |
| cmd_sp | input | PTR_W | Stack pointer taken at acquire |
| snp_valid | input | 1 | Remote invalidate or write present |
| snp_line | input | LINE_W | Line address of the snoop |
| txn_phase | output | 2 | 0 idle, 1 gathering, 2 critical section |
| line_count | output | CNT_W | Number of tracked lines |
| done_valid | output | 1 | Transaction ended (one-cycle pulse) |
| done_code | output | 3 | Reason for the ending |
| rb_valid | output | 1 | Rollback pointers valid |
| rb_ip | output | PTR_W | Checkpointed instruction pointer |
| rb_sp | output | PTR_W | Checkpointed stack pointer |

## Verification
The assertions assume that the core uses the same line address width for loads, stores and snoops. They also assume that a command and a snoop in one cycle are each judged against the entries as they stood before that cycle's edge. The stimulus draws line addresses from a pool of eleven values. This makes duplicate loads, overflow past eight lines and snoop hits frequent. Commands and snoops are applied one cycle at a time, and the bench's own model predicts every completion, code and pointer pair.

// File: rtl/txn_pkg.sv
package txn_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PLOAD  = 3'd1,
        OP_ACQ    = 3'd2,
        OP_STORE  = 3'd3,
        OP_COMMIT = 3'd4,
        OP_ABORT  = 3'd5
    } txn_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GATHER = 2'd1,
        PH_CRIT   = 2'd2
    } txn_phase_e;

    typedef enum logic [2:0] {
        END_OK       = 3'd0,
        END_CAPACITY = 3'd1,
        END_CONFLICT = 3'd2,
        END_STRAY    = 3'd3,
        END_USER     = 3'd4,
        END_ORDER    = 3'd5
    } txn_end_e;
endpackage

// File: rtl/txn_line_cam.sv
module txn_line_cam #(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = 26,
    localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              alloc_en,
    input  logic [LINE_W-1:0] look_line,
    input  logic [LINE_W-1:0] snoop_line,
    output logic              look_hit,
    output logic              snoop_hit,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    logic [NUM_LINES-1:0] valid;
    logic [LINE_W-1:0]    tag [NUM_LINES];
    logic [NUM_LINES-1:0] look_match;
    logic [NUM_LINES-1:0] snoop_match;

    // entries fill in order because they are only ever released all together
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
                tag[i]   <= '0;
            end else if (clear) begin
                valid[i] <= 1'b0;
            end else if (alloc_en && count == CNT_W'(i)) begin
                valid[i] <= 1'b1;
                tag[i]   <= look_line;
            end
        end
        assign look_match[i]  = valid[i] && (tag[i] == look_line);
        assign snoop_match[i] = valid[i] && (tag[i] == snoop_line);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (clear)    count <= '0;
        else if (alloc_en) count <= count + 1'b1;
    end

    assign look_hit  = |look_match;
    assign snoop_hit = |snoop_match;
    assign full      = (count == CNT_W'(NUM_LINES));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(NUM_LINES));
    // R3
    no_dup_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (!look_hit && !full));
    // R3
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_match));
    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && valid == '0));
endmodule

// File: rtl/txn_ckpt.sv
module txn_ckpt #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [PTR_W-1:0] ip_in,
    input  logic [PTR_W-1:0] sp_in,
    output logic [PTR_W-1:0] ip_q,
    output logic [PTR_W-1:0] sp_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= '0;
            sp_q <= '0;
        end else if (capture) begin
            ip_q <= ip_in;
            sp_q <= sp_in;
        end
    end

    // R7
    ckpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(ip_q) && $stable(sp_q)));
endmodule

// File: rtl/txn_line_tracker.sv
module txn_line_tracker
    import txn_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = 26,
    parameter int PTR_W     = 32,
    localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic [PTR_W-1:0]  cmd_ip,
    input  logic [PTR_W-1:0]  cmd_sp,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    output logic [1:0]        txn_phase,
    output logic [CNT_W-1:0]  line_count,
    output logic              done_valid,
    output logic [2:0]        done_code,
    output logic              rb_valid,
    output logic [PTR_W-1:0]  rb_ip,
    output logic [PTR_W-1:0]  rb_sp
);
    txn_phase_e st, st_nxt;
    logic       disturbed, dist_nxt;
    txn_op_e    op;

    logic       cam_hit, cam_snp_hit, cam_full;
    logic       alloc, clear_all, take_ckpt;
    logic       fin, fin_rb;
    txn_end_e   fin_code;
    logic       snp_hit_v;
    logic [PTR_W-1:0] ck_ip, ck_sp;

    assign op        = cmd_valid ? txn_op_e'(cmd_op) : OP_NOP;
    assign snp_hit_v = snp_valid && cam_snp_hit;

    txn_line_cam #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_all),
        .alloc_en   (alloc),
        .look_line  (cmd_line),
        .snoop_line (snp_line),
        .look_hit   (cam_hit),
        .snoop_hit  (cam_snp_hit),
        .full       (cam_full),
        .count      (line_count)
    );

    txn_ckpt #(.PTR_W(PTR_W)) u_ckpt (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (take_ckpt),
        .ip_in   (cmd_ip),
        .sp_in   (cmd_sp),
        .ip_q    (ck_ip),
        .sp_q    (ck_sp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PH_IDLE;
            disturbed <= 1'b0;
        end else begin
            st        <= st_nxt;
            disturbed <= dist_nxt;
        end
    end

    // next state and per-cycle decisions
    always_comb begin
        st_nxt    = st;
        dist_nxt  = disturbed;
        alloc     = 1'b0;
        take_ckpt = 1'b0;
        fin       = 1'b0;
        fin_rb    = 1'b0;
        fin_code  = END_OK;
        unique case (st)
            PH_IDLE: begin
                dist_nxt = 1'b0;
                if (op == OP_PLOAD) begin
                    alloc  = 1'b1;
                    st_nxt = PH_GATHER;
                end
            end
            PH_GATHER: begin
                if (snp_hit_v) dist_nxt = 1'b1;
                case (op)
                    OP_PLOAD: begin
                        if (!cam_hit) begin
                            if (cam_full) begin
                                fin      = 1'b1;
                                fin_code = END_CAPACITY;
                            end else begin
                                alloc = 1'b1;
                            end
                        end
                    end
                    OP_ACQ: begin
                        if (disturbed || snp_hit_v) begin
                            fin      = 1'b1;
                            fin_code = END_CONFLICT;
                        end else begin
                            take_ckpt = 1'b1;
                            st_nxt    = PH_CRIT;
                        end
                    end
                    OP_STORE, OP_COMMIT: begin
                        fin      = 1'b1;
                        fin_code = END_ORDER;
                    end
                    OP_ABORT: begin
                        fin      = 1'b1;
                        fin_code = END_USER;
                    end
                    default: ;
                endcase
            end
            PH_CRIT: begin
                if (snp_hit_v) begin
                    fin      = 1'b1;
                    fin_rb   = 1'b1;
                    fin_code = END_CONFLICT;
                end else begin
                    case (op)
                        OP_STORE: begin
                            if (!cam_hit) begin
                                fin      = 1'b1;
                                fin_rb   = 1'b1;
                                fin_code = END_STRAY;
                            end
                        end
                        OP_COMMIT: begin
                            fin      = 1'b1;
                            fin_code = END_OK;
                        end
                        OP_ABORT: begin
                            fin      = 1'b1;
                            fin_rb   = 1'b1;
                            fin_code = END_USER;
                        end
                        default: ;
                    endcase
                end
            end
            default: st_nxt = PH_IDLE;
        endcase
        if (fin) begin
            st_nxt   = PH_IDLE;
            dist_nxt = 1'b0;
        end
    end

    assign clear_all = fin;
    assign txn_phase = st;

    // registered completion outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_code  <= END_OK;
            rb_valid   <= 1'b0;
            rb_ip      <= '0;
            rb_sp      <= '0;
        end else begin
            done_valid <= fin;
            done_code  <= fin ? fin_code : END_OK;
            rb_valid   <= fin_rb;
            rb_ip      <= fin_rb ? ck_ip : '0;
            rb_sp      <= fin_rb ? ck_sp : '0;
        end
    end

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (txn_phase == PH_IDLE && line_count == '0));
    // R10
    rb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> (done_valid && done_code != END_OK));
    // R5
    crit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_CRIT && $past(st) != PH_CRIT) |-> ($past(st) == PH_GATHER && $past(op) == OP_ACQ));
    // R9
    order_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_code == END_ORDER) |-> ($past(st) == PH_GATHER && !rb_valid));
    // R13
    crit_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_CRIT && snp_valid && cam_snp_hit) |=> (done_valid && done_code == END_CONFLICT && rb_valid));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && op != OP_PLOAD) |=> (!done_valid && txn_phase == PH_IDLE));
endmodule

// File: tb/tb_txn_line_tracker.sv
module tb_txn_line_tracker;
    localparam int N  = 8;
    localparam int LW = 26;
    localparam int PW = 32;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [LW-1:0] cmd_line;
    logic [PW-1:0] cmd_ip, cmd_sp;
    logic          snp_valid;
    logic [LW-1:0] snp_line;
    logic [1:0]    txn_phase;
    logic [CW-1:0] line_count;
    logic          done_valid;
    logic [2:0]    done_code;
    logic          rb_valid;
    logic [PW-1:0] rb_ip, rb_sp;

    always #5 clk = ~clk;

    txn_line_tracker #(.NUM_LINES(N), .LINE_W(LW), .PTR_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_line(cmd_line), .cmd_ip(cmd_ip), .cmd_sp(cmd_sp),
        .snp_valid(snp_valid), .snp_line(snp_line), .txn_phase(txn_phase),
        .line_count(line_count), .done_valid(done_valid), .done_code(done_code),
        .rb_valid(rb_valid), .rb_ip(rb_ip), .rb_sp(rb_sp)
    );

    int total = 0;
    int fails = 0;

    // reference model state
    int            m_phase = 0;
    logic [LW-1:0] m_lines[$];
    bit            m_dist = 0;
    logic [PW-1:0] m_ip = '0, m_sp = '0;

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit tracked(logic [LW-1:0] l);
        foreach (m_lines[i]) if (m_lines[i] == l) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(int op, logic [LW-1:0] line, logic [PW-1:0] ip, logic [PW-1:0] sp,
                        bit sv, logic [LW-1:0] sl);
        bit   e_done = 0, e_rb = 0;
        int   e_code = 0;
        bit   hit, shit;
        string tag = "R12";
        hit  = tracked(line);
        shit = sv && tracked(sl);
        case (m_phase)
            0: if (op == 1) begin m_lines.push_back(line); m_phase = 1; tag = "R2"; end
            1: begin
                if (shit) begin m_dist = 1; tag = "R6"; end
                else tag = "R2";
                case (op)
                    1: if (hit) tag = "R3";
                       else if (m_lines.size() < N) begin m_lines.push_back(line); tag = "R2"; end
                       else begin e_done = 1; e_code = 1; tag = "R4"; end
                    2: if (m_dist) begin e_done = 1; e_code = 2; tag = "R6"; end
                       else begin m_ip = ip; m_sp = sp; m_phase = 2; tag = "R5"; end
                    3, 4: begin e_done = 1; e_code = 5; tag = "R9"; end
                    5: begin e_done = 1; e_code = 4; tag = "R10"; end
                    default: ;
                endcase
            end
            default: begin
                tag = "R5";
                if (shit) begin e_done = 1; e_rb = 1; e_code = 2; tag = (op != 0) ? "R13" : "R7"; end
                else case (op)
                    3: if (hit) tag = "R8";
                       else begin e_done = 1; e_rb = 1; e_code = 3; tag = "R8"; end
                    4: begin e_done = 1; e_code = 0; tag = "R10"; end
                    5: begin e_done = 1; e_rb = 1; e_code = 4; tag = "R10"; end
                    default: ;
                endcase
            end
        endcase
        cmd_valid = (op != 0);
        cmd_op    = 3'(op);
        cmd_line  = line;
        cmd_ip    = ip;
        cmd_sp    = sp;
        snp_valid = sv;
        snp_line  = sl;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        snp_valid = 1'b0;
        chk(tag, "done_valid", done_valid, e_done);
        if (e_done) chk(tag, "done_code", done_code, e_code);
        chk(tag, "rb_valid", rb_valid, e_rb);
        if (e_rb) begin
            chk(tag, "rb_ip", rb_ip, m_ip);
            chk(tag, "rb_sp", rb_sp, m_sp);
        end
        if (e_done) begin
            m_lines.delete();
            m_phase = 0;
            m_dist  = 0;
            if (tag != "R12") chk("R11", "phase_after_end", txn_phase, 0);
        end
        chk(tag, "phase", txn_phase, m_phase);
        chk(tag, "count", line_count, m_lines.size());
    endtask

    initial begin
        #2_000_000;
        fails++;
        total++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_op = '0; cmd_line = '0; cmd_ip = '0; cmd_sp = '0;
        snp_valid = 1'b0; snp_line = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "phase", txn_phase, 0);
        chk("R1", "count", line_count, 0);
        chk("R1", "done_valid", done_valid, 0);
        chk("R1", "rb_valid", rb_valid, 0);

        // R12 idle ignores non-load commands and snoops
        step(3, 26'd5, 0, 0, 1, 26'd5);
        step(2, 0, 32'h11, 32'h22, 0, 0);
        step(4, 0, 0, 0, 0, 0);
        step(5, 0, 0, 0, 1, 26'd9);

        // R2/R3/R4 fill, duplicate, overflow
        for (int i = 0; i < N; i++) step(1, LW'(100 + i), 0, 0, 0, 0);
        step(1, 26'd103, 0, 0, 0, 0);
        step(1, 26'd200, 0, 0, 0, 0);

        // R5/R8/R10 success path
        step(1, 26'd7, 0, 0, 0, 0);
        step(1, 26'd8, 0, 0, 1, 26'd55);
        step(2, 0, 32'hDEAD_0001, 32'hBEEF_0002, 0, 0);
        step(3, 26'd8, 0, 0, 0, 0);
        step(4, 0, 0, 0, 0, 0);

        // R6 disturbance before acquire
        step(1, 26'd7, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 26'd7);
        step(2, 0, 32'h1, 32'h2, 0, 0);
        // R6 same-cycle snoop with acquire
        step(1, 26'd9, 0, 0, 0, 0);
        step(2, 0, 32'h3, 32'h4, 1, 26'd9);

        // R7 snoop in critical section
        step(1, 26'd12, 0, 0, 0, 0);
        step(2, 0, 32'hAAAA_1111, 32'h5555_2222, 0, 0);
        step(0, 0, 0, 0, 1, 26'd12);
        // R8 stray store
        step(1, 26'd12, 0, 0, 0, 0);
        step(2, 0, 32'h0C0C_0001, 32'h0D0D_0002, 0, 0);
        step(3, 26'd13, 0, 0, 0, 0);
        // R13 snoop beats commit
        step(1, 26'd14, 0, 0, 0, 0);
        step(2, 0, 32'h77, 32'h88, 0, 0);
        step(4, 0, 0, 0, 1, 26'd14);
        // R9 early store and commit, R10 aborts
        step(1, 26'd15, 0, 0, 0, 0);
        step(3, 26'd15, 0, 0, 0, 0);
        step(1, 26'd15, 0, 0, 0, 0);
        step(4, 0, 0, 0, 0, 0);
        step(1, 26'd15, 0, 0, 0, 0);
        step(5, 0, 0, 0, 0, 0);
        step(1, 26'd15, 0, 0, 0, 0);
        step(2, 0, 32'h99, 32'h9A, 0, 0);
        step(5, 0, 0, 0, 0, 0);

        // constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            int r, op;
            r = int'($urandom % 16);
            if (r < 7) op = 1;
            else if (r == 7) op = 2;
            else if (r < 11) op = 3;
            else if (r == 11) op = 4;
            else if (r == 12) op = 5;
            else op = 0;
            step(op, LW'($urandom % 11), $urandom, $urandom,
                 ($urandom % 10) == 0, LW'($urandom % 11));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule